// File: doc/BRIEF.md
# Delayed Transceiver Enable for Slot Read Cycles

This block drives the output-enable of an external bidirectional bus transceiver that sits between a peripheral card's logic and a host's 5 V data bus. When the host reads from the card, the card must put its data on the bus. The host's own data-bus driver does not let go at once when the slot select goes low. It can keep driving for 30 ns, and on some machines for more than 70 ns. If the card enabled its transceiver at once, the two drivers would fight. The block therefore holds the enable off for a fixed number of fast-clock cycles, about 140 ns, after a qualifying read begins. It releases the enable with no clock delay at all when the cycle ends.

A qualifying read means all of the following at once: at least one of the three active-low slot selects (device select, I/O select, I/O strobe) is low, read/write is high, and phase-2 is high. All five inputs pass through a synchronizer before they reach the delay counter. The synchronizer latency counts as part of the delay. The enable pin is active low, so an external pull-up keeps the transceiver off while the card's logic is unconfigured. The block has no data path, so all of its pins are plain control signals and none uses a valid/ready handshake.

Top module: `slot_oe_delay`

## Requirements
- R1: While `rst_n` is low, `bus_oe_n` is high (transceiver off). Reset takes effect without waiting for a clock edge, and after reset the enable stays off until a new delay has completed.
- R2: A cycle is a qualifying read when any one of `devsel_n`, `iosel_n` or `iostrb_n` is low (0 = selected) while `rw` is 1 (read) and `phi2` is 1. Each of the three selects on its own is enough to start the delay.
- R3: Count rising edges of `clk` from the first edge that samples the qualifying condition. `bus_oe_n` goes low just after edge number `DELAY_CYCLES` (default 18, which is 144 ns at 125 MHz). It stays high after every earlier edge. The count includes the `SYNC_STAGES` (default 2) synchronizer flops.
- R4: When all three selects return high, `bus_oe_n` returns high in the same clock cycle, with no clock edge in between.
- R5: When `phi2` falls, `bus_oe_n` returns high in the same clock cycle, with no clock edge in between.
- R6: When `rw` is 0 (write), `bus_oe_n` stays high, even if a select is held low far longer than `DELAY_CYCLES` edges.
- R7: If a qualifying condition lasts for fewer than `DELAY_CYCLES` edges and then ends, `bus_oe_n` never goes low.
- R8: After the qualifying condition has been absent for at least `SYNC_STAGES`+1 edges, a new qualifying read waits the full `DELAY_CYCLES` edges again before `bus_oe_n` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast internal clock that times the delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| devsel_n | input | 1 | Device select strobe, active low |
| iosel_n | input | 1 | I/O select strobe, active low |
| iostrb_n | input | 1 | I/O strobe, active low |
| rw | input | 1 | Host read/write, 1 = read |
| phi2 | input | 1 | Host phase-2 clock |
| bus_oe_n | output | 1 | Transceiver output enable, active low |

## Verification
The bench runs a long read on each of the three selects alone. This shows that every select qualifies on its own, and it checks the exact edge on which the enable turns on. A select held low during a write, and a read that is cut short one edge before the delay ends, check that a long select alone is not enough and that a short read never drives the bus. The bench also ends cycles by raising the selects, by dropping phase-2 and by asserting reset. It samples before the next clock edge each time, which separates a combinational release from a registered one. A restarted read after a gap confirms that the delay counter starts again from zero.

// File: rtl/slot_oe_pkg.sv
package slot_oe_pkg;

  // Host-side slot signals gathered into one bundle so they can be synchronized together.
  typedef struct packed {
    logic devsel_n;
    logic iosel_n;
    logic iostrb_n;
    logic rw;
    logic phi2;
  } slot_bus_t;

  localparam int SLOT_BUS_W = $bits(slot_bus_t);

  // A read cycle that the card is allowed to answer.
  function automatic logic read_qualifies(input slot_bus_t b);
    return (~b.devsel_n | ~b.iosel_n | ~b.iostrb_n) & b.rw & b.phi2;
  endfunction

endpackage

// File: rtl/slot_oe_sync.sv
module slot_oe_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  input  logic [WIDTH-1:0] idle_val,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= idle_val;
        else        chain[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= idle_val;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/slot_oe_qual.sv
module slot_oe_qual
  import slot_oe_pkg::*;
(
  input  slot_bus_t bus,
  output logic      qualified
);

  assign qualified = read_qualifies(bus);

endmodule

// File: rtl/slot_oe_count.sv
module slot_oe_count #(
  parameter int DELAY_CYCLES = 18,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual_sync,
  output logic armed
);

  // Edges left to count once the synchronized qualifier is visible.
  localparam int HOLD = DELAY_CYCLES - SYNC_STAGES;
  localparam int CW   = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!qual_sync)     cnt <= '0;
    else if (cnt != HOLD_V)  cnt <= cnt + 1'b1;
  end

  assign armed = (cnt == HOLD_V);

endmodule

// File: rtl/slot_oe_delay.sv
module slot_oe_delay
  import slot_oe_pkg::*;
#(
  parameter int DELAY_CYCLES = 18,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic devsel_n,
  input  logic iosel_n,
  input  logic iostrb_n,
  input  logic rw,
  input  logic phi2,
  output logic bus_oe_n
);

  initial begin
    if (DELAY_CYCLES <= SYNC_STAGES || SYNC_STAGES < 1)
      $error("slot_oe_delay: DELAY_CYCLES must exceed SYNC_STAGES >= 1");
  end

  slot_bus_t raw_bus, sync_bus;
  slot_bus_t idle_bus;
  logic      qual_raw, qual_sync, armed;

  assign raw_bus  = '{devsel_n: devsel_n, iosel_n: iosel_n, iostrb_n: iostrb_n,
                      rw: rw, phi2: phi2};
  assign idle_bus = '{devsel_n: 1'b1, iosel_n: 1'b1, iostrb_n: 1'b1,
                      rw: 1'b1, phi2: 1'b0};

  slot_oe_sync #(.WIDTH(SLOT_BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_bus),
    .idle_val (idle_bus),
    .sync_out (sync_bus)
  );

  // Synchronized view feeds the delay counter.
  slot_oe_qual u_qual_sync (.bus(sync_bus), .qualified(qual_sync));

  // Raw view gates the output so release needs no clock edge.
  slot_oe_qual u_qual_raw (.bus(raw_bus), .qualified(qual_raw));

  slot_oe_count #(.DELAY_CYCLES(DELAY_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .qual_sync (qual_sync),
    .armed     (armed)
  );

  assign bus_oe_n = ~(armed & qual_raw & rst_n);

endmodule

// File: rtl/slot_oe_delay_chk.sv
module slot_oe_delay_chk #(
  parameter int DELAY_CYCLES = 18
) (
  input logic clk,
  input logic rst_n,
  input logic devsel_n,
  input logic iosel_n,
  input logic iostrb_n,
  input logic rw,
  input logic phi2,
  input logic bus_oe_n
);

  localparam int RW_ = $clog2(DELAY_CYCLES + 2);
  localparam logic [RW_-1:0] TOP = RW_'(DELAY_CYCLES + 1);
  localparam logic [RW_-1:0] DV  = RW_'(DELAY_CYCLES);

  logic qual;
  logic [RW_-1:0] run;

  assign qual = (!devsel_n || !iosel_n || !iostrb_n) && rw && phi2;

  // Consecutive edges that sampled a qualifying read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run <= '0;
    else if (!qual)    run <= '0;
    else if (run != TOP) run <= run + 1'b1;
  end

  assert_reset_off_R1: assert property (@(posedge clk) !rst_n |-> bus_oe_n);

  assert_no_early_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe_n) |-> (run >= DV));

  assert_enable_after_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && run >= DV) |-> !bus_oe_n);

  assert_selects_idle_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel_n && iosel_n && iostrb_n) |-> bus_oe_n);

  assert_phi2_low_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> bus_oe_n);

  assert_write_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |-> bus_oe_n);

endmodule

bind slot_oe_delay slot_oe_delay_chk #(.DELAY_CYCLES(DELAY_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .devsel_n (devsel_n),
  .iosel_n  (iosel_n),
  .iostrb_n (iostrb_n),
  .rw       (rw),
  .phi2     (phi2),
  .bus_oe_n (bus_oe_n)
);

// File: tb/slot_oe_delay_tb.sv
`timescale 1ns/1ps
module slot_oe_delay_tb;

  localparam int D = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic devsel_n = 1'b1, iosel_n = 1'b1, iostrb_n = 1'b1;
  logic rw = 1'b1, phi2 = 1'b1;
  logic bus_oe_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slot_oe_delay #(.DELAY_CYCLES(D), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .devsel_n(devsel_n), .iosel_n(iosel_n),
    .iostrb_n(iostrb_n), .rw(rw), .phi2(phi2), .bus_oe_n(bus_oe_n)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%b expected=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic release_all();
    devsel_n = 1'b1; iosel_n = 1'b1; iostrb_n = 1'b1; rw = 1'b1; phi2 = 1'b1;
  endtask

  // Holds a read on the chosen select; checks the enable edge by edge.
  task automatic t_read(input int which);
    @(negedge clk);
    case (which)
      0: devsel_n = 1'b0;
      1: iosel_n  = 1'b0;
      default: iostrb_n = 1'b0;
    endcase
    for (int k = 1; k <= D + 2; k++) begin
      @(posedge clk); @(negedge clk);
      check(bus_oe_n, (k >= D) ? 1'b0 : 1'b1, (k >= D) ? "R2" : "R3",
            $sformatf("select %0d after edge %0d", which, k));
    end
    release_all();
    #1 check(bus_oe_n, 1'b1, "R4", "selects released");
    idle(4);
  endtask

  task automatic t_write_long();
    @(negedge clk);
    rw = 1'b0; devsel_n = 1'b0;
    for (int k = 1; k <= 2 * D; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == D || k == 2 * D) check(bus_oe_n, 1'b1, "R6", $sformatf("write edge %0d", k));
      else if (bus_oe_n !== 1'b1) check(bus_oe_n, 1'b1, "R6", "write mid");
    end
    release_all();
    idle(4);
  endtask

  task automatic t_short();
    logic seen;
    seen = 1'b1;
    @(negedge clk);
    iosel_n = 1'b0;
    for (int k = 1; k <= D - 1; k++) begin
      @(posedge clk); @(negedge clk);
      seen = seen & bus_oe_n;
    end
    release_all();
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      seen = seen & bus_oe_n;
    end
    check(seen, 1'b1, "R7", "short read never enabled");
  endtask

  task automatic t_phi2_restart();
    @(negedge clk);
    devsel_n = 1'b0;
    idle(D + 1);
    check(bus_oe_n, 1'b0, "R3", "enabled before phi2 drop");
    phi2 = 1'b0;
    #1 check(bus_oe_n, 1'b1, "R5", "phi2 fell");
    idle(3);
    phi2 = 1'b1;
    for (int k = 1; k <= D; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == D - 1) check(bus_oe_n, 1'b1, "R8", "restart edge D-1");
      if (k == D)     check(bus_oe_n, 1'b0, "R8", "restart edge D");
    end
    release_all();
    idle(4);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    iostrb_n = 1'b0;
    idle(D + 1);
    check(bus_oe_n, 1'b0, "R3", "enabled before reset");
    rst_n = 1'b0;
    #1 check(bus_oe_n, 1'b1, "R1", "reset mid-enable");
    idle(2);
    rst_n = 1'b1;
    for (int k = 1; k <= D; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == D - 1) check(bus_oe_n, 1'b1, "R1", "post-reset edge D-1");
      if (k == D)     check(bus_oe_n, 1'b0, "R1", "post-reset edge D");
    end
    release_all();
    idle(4);
  endtask

  initial begin
    idle(2);
    check(bus_oe_n, 1'b1, "R1", "in reset");
    devsel_n = 1'b0;
    idle(2);
    check(bus_oe_n, 1'b1, "R1", "in reset with select low");
    devsel_n = 1'b1;
    rst_n = 1'b1;
    idle(3);
    check(bus_oe_n, 1'b1, "R1", "after reset idle");
    t_read(0);
    t_read(1);
    t_read(2);
    t_write_long();
    t_short();
    t_phi2_restart();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule